// File: doc/BRIEF.md
# Dual-Reload PWM Timer Channel

A single down-counting timer channel that can also act as a pulse-width modulated source. Software sets a low-phase length and a high-phase length in two separate reload registers, then enables the channel. The counter counts down once per clock. When it reaches zero it reloads, and in PWM mode the output switches level. The low phase always comes first after enabling. A phase lasts its reload value plus one clock, so every phase is at least one clock long. The output therefore never stays at a constant 0% or 100% duty cycle while it is running.

The channel also offers a free-running mode. In that mode the counter wraps from zero to all ones and the output stays low. Each time the count expires, an interrupt flag is set, unless the mask bit blocks it. Software clears the flag by reading a dedicated acknowledge address. All control goes through a simple bus of one-cycle write and read strobes. Read data is registered and valid from the cycle after the read strobe.

Register map (byte addresses): 0x00 low reload, 0x04 high reload, 0x08 control, 0x0C current count (read only), 0x10 acknowledge (a read returns the flag and clears it), 0x14 flag (a read does not clear it). Unmapped addresses read as zero.

Top module: `pwm_reload_timer`

## Requirements
- R1: After a synchronous active-low reset, all registers, the count and the interrupt flag are zero, and `pwm_out` and `irq_o` are low.
- R2: A control write that sets the enable bit (bit 0) while the channel is disabled loads the low reload value into the count at that same clock edge. It also puts the output in its low phase.
- R3: With the enable, user-reload (bit 1) and PWM (bit 3) bits set, `pwm_out` is low for low reload + 1 cycles. It is then high for high reload + 1 cycles, and the pair repeats.
- R4: While the channel is enabled and the count is non-zero, the count decreases by one every clock. It can be read at address 0x0C.
- R5: While the channel is disabled, the count is frozen and `pwm_out` is low. The reload registers still accept writes and read back what was written.
- R6: In free-running mode (bit 1 = 0), a count of zero wraps to all ones on the next clock, and `pwm_out` stays low.
- R7: A reload register written while the channel runs does not change the phase in progress. The new value is used at the next reload of the phase that register controls.
- R8: Each expiry (count zero while enabled) sets the interrupt flag when the mask bit (bit 2) is clear. While the mask bit is set, an expiry leaves the flag unchanged. `irq_o` shows the flag.
- R9: A read of 0x10 returns the flag in bit 0 and clears it. An expiry in the same cycle takes priority and leaves the flag set.
- R10: Control bit layout: bit 0 enable, bit 1 reload mode (1 = user reload), bit 2 interrupt mask, bit 3 PWM output. A read at 0x08 returns these four bits, and all higher bits read as zero.
- R11: In user-reload mode with the PWM bit clear, every expiry reloads the low value and `pwm_out` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Registered read data, valid after the read strobe |
| pwm_out | output | 1 | PWM output |
| irq_o | output | 1 | Interrupt flag |

## Verification
The assertions assume that a read and a write are never strobed in the same cycle. They also assume that reset is applied once at the start and not again mid-run. The stimulus keeps to this because every bus access goes through a task that raises exactly one strobe for one cycle. The enable-start check relies on the enable rising only from a disabled state, so the bench always writes a disabling control value before it writes an enabling one. A behavioural reference model in the bench runs alongside the design and is compared on every clock.

// File: rtl/pwmt_pkg.sv
// Package: shared register offsets and the control register layout for
// the dual-reload PWM timer. Assumes byte addressing on 32-bit registers.
package pwmt_pkg;
    localparam int OFF_LOW   = 'h00;
    localparam int OFF_HIGH  = 'h04;
    localparam int OFF_CTRL  = 'h08;
    localparam int OFF_COUNT = 'h0C;
    localparam int OFF_ACK   = 'h10;
    localparam int OFF_FLAG  = 'h14;
    localparam int CTRL_W    = 4;

    // Control fields, bit 0 at the bottom.
    typedef struct packed {
        logic pwm;   // bit 3
        logic mask;  // bit 2
        logic user;  // bit 1
        logic en;    // bit 0
    } ctrl_t;
endpackage

// File: rtl/pwmt_regs.sv
// Register file: holds both reload values and the control bits. It decodes
// bus writes, produces the start pulse and the acknowledge pulse, and
// registers the read data. Assumes rd_en and wr_en are never high together.
module pwmt_regs #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [CNT_W-1:0]      wdata,
    input  logic [CNT_W-1:0]      count_i,
    input  logic                  flag_i,
    output logic [CNT_W-1:0]      rdata,
    output logic [CNT_W-1:0]      low_q,
    output logic [CNT_W-1:0]      high_q,
    output pwmt_pkg::ctrl_t       ctrl_q,
    output logic                  start_o,
    output logic                  ack_o
);
    import pwmt_pkg::*;

    localparam int PAD_W = CNT_W - CTRL_W;

    logic sel_low, sel_high, sel_ctrl, sel_count, sel_ack, sel_flag;
    logic [CNT_W-1:0] rd_mux;

    // Address decode for each register.
    always_comb begin
        sel_low   = (addr == ADDR_W'(OFF_LOW));
        sel_high  = (addr == ADDR_W'(OFF_HIGH));
        sel_ctrl  = (addr == ADDR_W'(OFF_CTRL));
        sel_count = (addr == ADDR_W'(OFF_COUNT));
        sel_ack   = (addr == ADDR_W'(OFF_ACK));
        sel_flag  = (addr == ADDR_W'(OFF_FLAG));
    end

    // Start when a control write raises enable from the disabled state.
    assign start_o = wr_en && sel_ctrl && wdata[0] && !ctrl_q.en;
    // Acknowledge pulse on a read of the clearing address.
    assign ack_o   = rd_en && sel_ack;

    // Reload and control register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q  <= '0;
            high_q <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            if (sel_low)  low_q  <= wdata;
            if (sel_high) high_q <= wdata;
            if (sel_ctrl) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    // Read data select.
    always_comb begin
        rd_mux = '0;
        if (sel_low)                rd_mux = low_q;
        if (sel_high)               rd_mux = high_q;
        if (sel_ctrl)               rd_mux = {{PAD_W{1'b0}}, ctrl_q};
        if (sel_count)              rd_mux = count_i;
        if (sel_ack || sel_flag)    rd_mux = {{(CNT_W-1){1'b0}}, flag_i};
    end

    // Registered read data, held until the next read.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    // R10: a control write is reflected in the control bits on the next cycle.
    a_r10_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_ctrl) |=> (ctrl_q == ctrl_t'($past(wdata[CTRL_W-1:0]))));
endmodule

// File: rtl/pwmt_core.sv
// Counter core: the down-counter and the phase state. On a start pulse it
// loads the low value. While enabled it counts down, and at zero it reloads
// according to the mode: alternating low and high in PWM user mode, low
// only in plain user mode, or wrapping to all ones in free mode.
// Assumes start_i is only high while en_i is low.
module pwmt_core #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             user_i,
    input  logic             pwm_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] low_i,
    input  logic [CNT_W-1:0] high_i,
    output logic [CNT_W-1:0] count_q,
    output logic             expiry_o,
    output logic             pwm_o
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic phase_hi_q;
    logic at_zero;

    assign at_zero  = (count_q == '0);
    assign expiry_o = en_i && at_zero;
    assign pwm_o    = en_i && pwm_i && phase_hi_q;

    // Count and phase update: start load, reload at zero, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q    <= '0;
            phase_hi_q <= 1'b0;
        end else if (start_i) begin
            count_q    <= low_i;
            phase_hi_q <= 1'b0;
        end else if (en_i) begin
            if (at_zero) begin
                if (!user_i) begin
                    count_q    <= ALL_ONES;
                    phase_hi_q <= 1'b0;
                end else if (pwm_i && !phase_hi_q) begin
                    count_q    <= high_i;
                    phase_hi_q <= 1'b1;
                end else begin
                    count_q    <= low_i;
                    phase_hi_q <= 1'b0;
                end
            end else begin
                count_q <= count_q - 1'b1;
            end
        end
    end

    // R2: a start loads the low value and enters the low phase.
    a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (count_q == $past(low_i)) && !phase_hi_q);
    // R4: a running, non-zero count decrements by one.
    a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !start_i && !at_zero) |=> (count_q == $past(count_q) - 1'b1));
    // R5: a disabled channel keeps its count.
    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !start_i) |=> $stable(count_q));
    // R6: free mode wraps zero to all ones.
    a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !user_i && at_zero) |=> (count_q == ALL_ONES));
    // R3: PWM user mode switches phase at each expiry.
    a_r3_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && user_i && pwm_i && at_zero) |=> (phase_hi_q != $past(phase_hi_q)));
endmodule

// File: rtl/pwmt_irq.sv
// Interrupt flag: set by an unmasked expiry and cleared by an acknowledge
// read. Setting wins over clearing in the same cycle.
module pwmt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic expiry_i,
    input  logic mask_i,
    input  logic ack_i,
    output logic flag_q
);
    logic set_w;
    assign set_w = expiry_i && !mask_i;

    // Flag storage with priority to setting.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (set_w) flag_q <= 1'b1;
        else if (ack_i) flag_q <= 1'b0;
    end

    // R8: an unmasked expiry sets the flag.
    a_r8_set: assert property (@(posedge clk) disable iff (!rst_n)
        (expiry_i && !mask_i) |=> flag_q);
    // R8: while masked, the flag is untouched unless acknowledged.
    a_r8_masked_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i && !ack_i) |=> $stable(flag_q));
    // R9: an acknowledge with no set clears the flag.
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !(expiry_i && !mask_i)) |=> !flag_q);
endmodule

// File: rtl/pwm_reload_timer.sv
// Top level of the dual-reload PWM timer channel. It connects the register
// file, the counter core and the interrupt flag. Assumes a single clock and
// a synchronous active-low reset.
module pwm_reload_timer #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              pwm_out,
    output logic              irq_o
);
    import pwmt_pkg::*;

    logic [CNT_W-1:0] low_w, high_w, count_w;
    ctrl_t            ctrl_w;
    logic             start_w, ack_w, expiry_w, flag_w;

    pwmt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .count_i(count_w), .flag_i(flag_w),
        .rdata(rdata), .low_q(low_w), .high_q(high_w), .ctrl_q(ctrl_w),
        .start_o(start_w), .ack_o(ack_w)
    );

    pwmt_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .en_i(ctrl_w.en), .user_i(ctrl_w.user),
        .pwm_i(ctrl_w.pwm), .start_i(start_w), .low_i(low_w),
        .high_i(high_w), .count_q(count_w), .expiry_o(expiry_w),
        .pwm_o(pwm_out)
    );

    pwmt_irq u_irq (
        .clk(clk), .rst_n(rst_n), .expiry_i(expiry_w), .mask_i(ctrl_w.mask),
        .ack_i(ack_w), .flag_q(flag_w)
    );

    assign irq_o = flag_w;

    // R1: out of reset both outputs are low.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!pwm_out && !irq_o && rdata == '0));
endmodule

// File: tb/pwm_reload_timer_test.sv
module pwm_reload_timer_test;
    localparam int CW = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [CW-1:0] wdata = '0;
    logic [CW-1:0] rdata;
    logic          pwm_out, irq_o;

    int checks = 0, failures = 0;
    bit done = 0;

    pwm_reload_timer #(.CNT_W(CW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out), .irq_o(irq_o));

    always #5 clk = ~clk;

    // Behavioural reference model
    longint m_low, m_high, m_count, m_rdata;
    int     m_ctrl;
    bit     m_phase, m_flag;

    always @(posedge clk) begin
        bit en, user, pwm, mask, expiry, start;
        en = m_ctrl[0]; user = m_ctrl[1]; mask = m_ctrl[2]; pwm = m_ctrl[3];
        if (!rst_n) begin
            m_low = 0; m_high = 0; m_count = 0; m_rdata = 0;
            m_ctrl = 0; m_phase = 0; m_flag = 0;
        end else begin
            expiry = en && (m_count == 0);
            start  = wr_en && addr == 5'h08 && wdata[0] && !en;
            if (rd_en) begin
                case (addr)
                    5'h00: m_rdata = m_low;
                    5'h04: m_rdata = m_high;
                    5'h08: m_rdata = m_ctrl;
                    5'h0C: m_rdata = m_count;
                    5'h10, 5'h14: m_rdata = m_flag;
                    default: m_rdata = 0;
                endcase
            end
            if (start) begin
                m_count = m_low; m_phase = 0;
            end else if (en) begin
                if (m_count == 0) begin
                    if (!user) begin m_count = 64'hFFFF_FFFF; m_phase = 0; end
                    else if (pwm && !m_phase) begin m_count = m_high; m_phase = 1; end
                    else begin m_count = m_low; m_phase = 0; end
                end else m_count = m_count - 1;
            end
            if (expiry && !mask) m_flag = 1;
            else if (rd_en && addr == 5'h10) m_flag = 0;
            if (wr_en) begin
                if (addr == 5'h00) m_low  = wdata;
                if (addr == 5'h04) m_high = wdata;
                if (addr == 5'h08) m_ctrl = int'(wdata[3:0]);
            end
        end
    end

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison against the model (R3 output, R8 flag, R9 read data)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3 pwm_out vs model", pwm_out, m_ctrl[0] & m_ctrl[3] & m_phase);
            check("R8 irq_o vs model", irq_o, m_flag);
            check("R9 rdata vs model", rdata, m_rdata);
        end
    end

    task automatic bus_write(input logic [AW-1:0] a, input logic [CW-1:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [CW-1:0] d);
        addr = a; rd_en = 1'b1;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (pwm_out == lvl && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [CW-1:0] d, d2;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 pwm_out", pwm_out, 0);
        check("R1 irq_o", irq_o, 0);
        bus_read(5'h00, d); check("R1 low reload", d, 0);
        bus_read(5'h08, d); check("R1 control", d, 0);
        bus_read(5'h0C, d); check("R1 count", d, 0);
        // R5 loads writable while disabled, count frozen
        bus_write(5'h00, 2);
        bus_write(5'h04, 4);
        bus_read(5'h00, d); check("R5 low readback", d, 2);
        bus_read(5'h0C, d); check("R5 count frozen", d, 0);
        // R3 phase widths, L=2 H=4
        bus_write(5'h08, 32'hB);
        run_len(0, n); check("R3 first low width", n, 3);
        run_len(1, n); check("R3 high width", n, 5);
        // R7 change high during the low phase
        bus_write(5'h04, 1);
        run_len(0, n); check("R7 rest of low", n, 2);
        run_len(1, n); check("R7 new high width", n, 2);
        run_len(0, n); check("R3 repeat low width", n, 3);
        // R10 readback
        bus_read(5'h08, d); check("R10 control readback", d, 32'hB);
        // disable; R9 acknowledge
        bus_write(5'h08, 32'hA);
        check("R5 output low when disabled", pwm_out, 0);
        bus_read(5'h0C, d); bus_read(5'h0C, d2); check("R5 frozen count", d2, d);
        bus_read(5'h10, d); check("R9 ack returns flag", d, 1);
        bus_read(5'h14, d); check("R9 flag cleared", d, 0);
        // R11 user mode without PWM
        bus_write(5'h08, 32'h3);
        n = 0;
        repeat (20) begin @(negedge clk); if (pwm_out) n++; end
        check("R11 output stays low", n, 0);
        bus_read(5'h0C, d); check("R11 count within low reload", d <= 2, 1);
        // R8 mask
        bus_write(5'h08, 32'h0);
        bus_read(5'h10, d);
        bus_write(5'h08, 32'h7);
        n = 0;
        repeat (12) begin @(negedge clk); if (irq_o) n++; end
        check("R8 masked irq stays low", n, 0);
        bus_write(5'h08, 32'h0);
        bus_read(5'h14, d); check("R8 masked flag", d, 0);
        // R6 free-running wrap
        bus_write(5'h00, 3);
        bus_write(5'h08, 32'h1);
        repeat (6) @(negedge clk);
        bus_read(5'h0C, d); check("R6 wrapped count", d, 32'hFFFF_FFFD);
        check("R6 output low", pwm_out, 0);
        bus_read(5'h14, d); check("R8 free-mode expiry flag", d, 1);
        // R2 restart loads low value
        bus_write(5'h08, 32'h0);
        bus_write(5'h00, 5);
        bus_write(5'h08, 32'h3);
        check("R2 output low after start", pwm_out, 0);
        bus_read(5'h0C, d); check("R2 count loaded", d, 5);
        bus_read(5'h0C, d); check("R4 count decremented", d, 4);
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule